// File: doc/BRIEF.md
# Link Training Register Write Sequencer

This block turns one set of transmitter training settings into the ordered series of single-byte register writes that a display link sink expects during a training step. On a start pulse it captures the active lane count, each lane's voltage-swing, pre-emphasis and post-cursor levels, the training pattern code, the sink revision code and the link-rate code. It then issues its writes one at a time on a sideband write port. That port stands in for an auxiliary-channel transaction engine, which lies outside this block.

The block writes the drive bytes for each active lane first. If the sink revision and the link rate allow it, it then writes the packed post-cursor bytes. The pattern byte always comes last. A controller calls the block once per training iteration, every time it changes the drive levels or the pattern. The block answers with a one-cycle done pulse, or with a one-cycle error pulse if the port reports a failed write.

Top module: `lt_write_seq`

## Requirements
- R1: Active lane i gets one drive byte at address 0x103+i. Bits [1:0] of that byte hold the lane's swing level, bits [4:3] hold its pre-emphasis level, and all other bits are zero.
- R2: The drive writes form one burst that starts at lane 0. Its length is the active lane count, which lane_mode encodes as 0 for 1 lane, 1 for 2 lanes, and 2 or 3 for 4 lanes.
- R3: Post-cursor bytes are written only when sink_rev is at least 0x12 and rate_code equals 0x14, the 5.4 Gb/s code. Otherwise no write goes to 0x10F or above.
- R4: Post-cursor byte j goes to address 0x10F+j. Bits [1:0] hold the level of lane 2j. Bits [5:4] hold the level of lane 2j+1 when that lane is active and are zero otherwise. All other bits are zero.
- R5: The post-cursor burst length is the active lane count divided by two, rounded up.
- R6: The last write of every sequence goes to address 0x102. Bits [1:0] of that byte carry the pattern code (0 means disabled, 1 to 3 select a pattern), and bit 5 is set exactly when the code is nonzero.
- R7: The write order is fixed: drive bytes, then post-cursor bytes if there are any, then the pattern byte.
- R8: A write request holds wr_valid, wr_addr and wr_data steady until it sees wr_ready. No further request is raised until wr_ack arrives.
- R9: busy is high from the cycle after an accepted start until the sequence ends. done pulses for one cycle right after the final write is acknowledged without error.
- R10: An acknowledgement with wr_err set ends the sequence at once. It raises error for one cycle, issues no further writes and gives no done.
- R11: A start request, or any change to the settings inputs, while busy is high has no effect on the writes in progress and does not begin a new sequence.
- R12: After reset the block is idle, with wr_valid, busy, done and error all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a write sequence (taken only when idle) |
| lane_mode | input | 2 | Active lane count code: 0 = 1 lane, 1 = 2 lanes, 2 or 3 = 4 lanes |
| swing_lvl | input | LANES*2 | Voltage-swing level for each lane, 2 bits per lane, lane 0 in the low bits |
| preemph_lvl | input | LANES*2 | Pre-emphasis level for each lane |
| postcur_lvl | input | LANES*2 | Post-cursor level for each lane |
| pattern_sel | input | 2 | Training pattern code, 0 = disabled |
| sink_rev | input | 8 | Sink revision code |
| rate_code | input | 8 | Link rate code (0x14 selects 5.4 Gb/s) |
| wr_valid | output | 1 | Write request pending |
| wr_addr | output | 16 | Register address of the pending write |
| wr_data | output | 8 | Data byte of the pending write |
| wr_ready | input | 1 | Port accepts the pending write |
| wr_ack | input | 1 | Port completes the outstanding write |
| wr_err | input | 1 | Marks the completion as failed (valid with wr_ack) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| error | output | 1 | One-cycle pulse when a sequence aborts |

## Verification
The main sweep covers every lane-count code together with every pattern code. Each of those pairs is run against revision codes just below and at the threshold, and against a rate code that matches the 5.4 Gb/s setting and one that does not. This separates the write counts for 1, 2 and 4 lanes with and without the post-cursor burst, and shows whether the scrambling-disable bit follows the pattern code. The per-lane levels shift with each run, so a swapped lane, a swapped nibble or a mis-shifted field produces a wrong byte at a known position. Stalls of varying length on wr_ready and ack delays of one and two cycles test the hold rules. Two separate runs test an error on a middle write, which must abort the sequence, and a start plus new settings applied while busy, which must not alter the write stream.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int LVL_W = 2;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] DRIVE_BASE = 16'h0103;
  localparam logic [ADDR_W-1:0] PC_BASE = 16'h010F;
  localparam logic [ADDR_W-1:0] PAT_ADDR = 16'h0102;
  localparam int SCRAMBLE_OFF_BIT = 5;
  localparam int PC_HI_SHIFT = 4;
  localparam int PE_SHIFT = 3;
  localparam logic [7:0] REV_MIN = 8'h12;
  localparam logic [7:0] RATE_FAST = 8'h14;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_state_t;

  function automatic logic [7:0] drive_byte(input logic [LVL_W-1:0] sw,
                                            input logic [LVL_W-1:0] pe);
    return 8'(sw) | (8'(pe) << PE_SHIFT);
  endfunction

  function automatic logic [7:0] pc_pair(input logic [LVL_W-1:0] lo,
                                         input logic [LVL_W-1:0] hi,
                                         input logic hi_used);
    return 8'(lo) | (hi_used ? (8'(hi) << PC_HI_SHIFT) : 8'h00);
  endfunction

  function automatic logic [7:0] pattern_byte(input logic [1:0] code);
    logic [7:0] b;
    b = 8'(code);
    if (code != 2'd0) b[SCRAMBLE_OFF_BIT] = 1'b1;
    return b;
  endfunction

  function automatic logic pc_allowed(input logic [7:0] rev, input logic [7:0] rate);
    return (rev >= REV_MIN) && (rate == RATE_FAST);
  endfunction
endpackage

// File: rtl/lts_plan.sv
module lts_plan #(
  parameter int LANES = 4,
  parameter int CW = 3
) (
  input  logic [1:0]    lane_mode,
  input  logic          pc_en,
  output logic [CW-1:0] n_drive,
  output logic [CW-1:0] n_pc,
  output logic [CW-1:0] last_idx
);
  always_comb begin
    case (lane_mode)
      2'd0:    n_drive = CW'(1);
      2'd1:    n_drive = CW'(2);
      default: n_drive = CW'(LANES);
    endcase
    n_pc = pc_en ? ((n_drive + CW'(1)) >> 1) : '0;
    last_idx = n_drive + n_pc;
  end
endmodule

// File: rtl/lts_byte_sel.sv
module lts_byte_sel
  import lts_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW = 3
) (
  input  logic [CW-1:0]          idx,
  input  logic [CW-1:0]          n_drive,
  input  logic [CW-1:0]          n_pc,
  input  logic [LANES*LVL_W-1:0] swing,
  input  logic [LANES*LVL_W-1:0] preemph,
  input  logic [LANES*LVL_W-1:0] postcur,
  input  logic [1:0]             pattern,
  output logic [ADDR_W-1:0]      addr,
  output logic [7:0]             data
);
  localparam int PAIRS = (LANES + 1) / 2;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int PW = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [7:0] drv_b [LANES];
  logic [7:0] pc_b  [PAIRS];
  logic [CW-1:0] pc_off;

  for (genvar g = 0; g < LANES; g++) begin : g_drv
    assign drv_b[g] = drive_byte(swing[g*LVL_W +: LVL_W], preemph[g*LVL_W +: LVL_W]);
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pc
    if (2*p + 1 < LANES) begin : g_two
      assign pc_b[p] = pc_pair(postcur[(2*p)*LVL_W +: LVL_W],
                               postcur[(2*p+1)*LVL_W +: LVL_W],
                               CW'(2*p + 1) < n_drive);
    end else begin : g_one
      assign pc_b[p] = pc_pair(postcur[(2*p)*LVL_W +: LVL_W], '0, 1'b0);
    end
  end

  assign pc_off = idx - n_drive;

  always_comb begin
    if (idx < n_drive) begin
      addr = DRIVE_BASE + ADDR_W'(idx);
      data = drv_b[idx[LW-1:0]];
    end else if (pc_off < n_pc) begin
      addr = PC_BASE + ADDR_W'(pc_off);
      data = pc_b[pc_off[PW-1:0]];
    end else begin
      addr = PAT_ADDR;
      data = pattern_byte(pattern);
    end
  end
endmodule

// File: rtl/lts_ctrl.sv
module lts_ctrl
  import lts_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] last_idx,
  input  logic          wr_ready,
  input  logic          wr_ack,
  input  logic          wr_err,
  output logic [CW-1:0] idx,
  output logic          take,
  output logic          wr_valid,
  output logic          busy,
  output logic          done,
  output logic          error
);
  seq_state_t state;
  logic fin_ok, fin_bad, step;

  assign take     = (state == ST_IDLE) && start;
  assign wr_valid = (state == ST_REQ);
  assign busy     = (state != ST_IDLE);
  assign fin_bad  = (state == ST_WAIT) && wr_ack && wr_err;
  assign fin_ok   = (state == ST_WAIT) && wr_ack && !wr_err && (idx == last_idx);
  assign step     = (state == ST_WAIT) && wr_ack && !wr_err && (idx != last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done  <= fin_ok;
      error <= fin_bad;
      case (state)
        ST_IDLE: if (take) begin
          state <= ST_REQ;
          idx   <= '0;
        end
        ST_REQ: if (wr_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (fin_bad || fin_ok) state <= ST_IDLE;
          else if (step) begin
            idx   <= idx + CW'(1);
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lt_write_seq.sv
module lt_write_seq
  import lts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             lane_mode,
  input  logic [LANES*LVL_W-1:0] swing_lvl,
  input  logic [LANES*LVL_W-1:0] preemph_lvl,
  input  logic [LANES*LVL_W-1:0] postcur_lvl,
  input  logic [1:0]             pattern_sel,
  input  logic [7:0]             sink_rev,
  input  logic [7:0]             rate_code,
  output logic                   wr_valid,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [7:0]             wr_data,
  input  logic                   wr_ready,
  input  logic                   wr_ack,
  input  logic                   wr_err,
  output logic                   busy,
  output logic                   done,
  output logic                   error
);
  localparam int CW = $clog2(LANES + (LANES + 1) / 2 + 1);

  logic [1:0]             mode_q;
  logic [LANES*LVL_W-1:0] swing_q, preemph_q, postcur_q;
  logic [1:0]             pat_q;
  logic                   pc_en_q;
  logic                   seq_take;
  logic [CW-1:0]          idx, n_drive, n_pc, last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      swing_q   <= '0;
      preemph_q <= '0;
      postcur_q <= '0;
      pat_q     <= '0;
      pc_en_q   <= 1'b0;
    end else if (seq_take) begin
      mode_q    <= lane_mode;
      swing_q   <= swing_lvl;
      preemph_q <= preemph_lvl;
      postcur_q <= postcur_lvl;
      pat_q     <= pattern_sel;
      pc_en_q   <= pc_allowed(sink_rev, rate_code);
    end
  end

  lts_plan #(.LANES(LANES), .CW(CW)) u_plan (
    .lane_mode(mode_q), .pc_en(pc_en_q),
    .n_drive(n_drive), .n_pc(n_pc), .last_idx(last_idx)
  );

  lts_byte_sel #(.LANES(LANES), .CW(CW)) u_sel (
    .idx(idx), .n_drive(n_drive), .n_pc(n_pc),
    .swing(swing_q), .preemph(preemph_q), .postcur(postcur_q),
    .pattern(pat_q), .addr(wr_addr), .data(wr_data)
  );

  lts_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .last_idx(last_idx),
    .wr_ready(wr_ready), .wr_ack(wr_ack), .wr_err(wr_err),
    .idx(idx), .take(seq_take), .wr_valid(wr_valid),
    .busy(busy), .done(done), .error(error)
  );
endmodule

// File: rtl/lts_chk.sv
module lts_chk
  import lts_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wr_ack,
  input logic              wr_err,
  input logic [1:0]        mode_q,
  input logic [1:0]        pat_q,
  input logic              pc_en_q
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R9
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_ack && !wr_err));
  // R10
  error_after_bad_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> $past(wr_ack && wr_err) && !done);
  // R6
  scramble_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == PAT_ADDR |-> wr_data[SCRAMBLE_OFF_BIT] == (wr_data[1:0] != 2'd0));
  // R7
  pattern_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_addr) == PAT_ADDR);
  // R3
  pc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr >= PC_BASE |-> pc_en_q);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);
  // R11
  snapshot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q) && $stable(pat_q) && $stable(pc_en_q));
endmodule

bind lt_write_seq lts_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_ack(wr_ack), .wr_err(wr_err), .mode_q(mode_q), .pat_q(pat_q), .pc_en_q(pc_en_q)
);

// File: tb/lt_write_seq_tb.sv
`timescale 1ns/1ps
module lt_write_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] lane_mode = '0;
  logic [7:0] swing_lvl = '0, preemph_lvl = '0, postcur_lvl = '0;
  logic [1:0] pattern_sel = '0;
  logic [7:0] sink_rev = '0, rate_code = '0;
  logic wr_valid, busy, done, error;
  logic [15:0] wr_addr;
  logic [7:0] wr_data;
  logic wr_ready = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;

  int checks = 0, fails = 0;
  int nwr = 0, err_at = 0, ack_due = 0, stall_cnt = 0;
  logic [15:0] got_addr [16];
  logic [7:0]  got_data [16];
  logic [15:0] exp_addr [8];
  logic [7:0]  exp_data [8];
  int exp_n = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lt_write_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_mode(lane_mode),
    .swing_lvl(swing_lvl), .preemph_lvl(preemph_lvl), .postcur_lvl(postcur_lvl),
    .pattern_sel(pattern_sel), .sink_rev(sink_rev), .rate_code(rate_code),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_ack(wr_ack), .wr_err(wr_err),
    .busy(busy), .done(done), .error(error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // port model: stalls ready, acknowledges after one or two cycles
  initial forever begin
    @(negedge clk);
    wr_ack = 1'b0; wr_err = 1'b0; wr_ready = 1'b0;
    if (ack_due > 0) begin
      ack_due--;
      if (ack_due == 0) begin
        wr_ack = 1'b1;
        wr_err = (nwr == err_at);
      end
    end else if (wr_valid) begin
      if (stall_cnt < (nwr % 3)) stall_cnt++;
      else begin
        wr_ready = 1'b1;
        if (nwr < 16) begin
          got_addr[nwr] = wr_addr;
          got_data[nwr] = wr_data;
        end
        nwr++;
        ack_due = 1 + (nwr % 2);
        stall_cnt = 0;
      end
    end
  end

  function automatic int lanes_of(input logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  task automatic set_levels(input int k);
    for (int i = 0; i < 4; i++) begin
      swing_lvl[2*i +: 2]   = 2'((k + i) % 4);
      preemph_lvl[2*i +: 2] = 2'((k + 2*i + 1) % 4);
      postcur_lvl[2*i +: 2] = 2'((3 * k + i + 2) % 4);
    end
  endtask

  task automatic build_expected(input logic [1:0] m, input logic [1:0] pat,
                                input logic [7:0] rev, input logic [7:0] rate);
    int n;
    n = lanes_of(m);
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      exp_addr[exp_n] = 16'h0103 + 16'(i);
      exp_data[exp_n] = {3'b000, preemph_lvl[2*i +: 2], 1'b0, swing_lvl[2*i +: 2]};
      exp_n++;
    end
    if (rev >= 8'h12 && rate == 8'h14) begin
      for (int j = 0; j < (n + 1) / 2; j++) begin
        exp_addr[exp_n] = 16'h010F + 16'(j);
        exp_data[exp_n] = {2'b00, (2*j + 1 < n) ? postcur_lvl[(2*j+1)*2 +: 2] : 2'b00,
                           2'b00, postcur_lvl[(2*j)*2 +: 2]};
        exp_n++;
      end
    end
    exp_addr[exp_n] = 16'h0102;
    exp_data[exp_n] = {2'b00, (pat != 2'd0), 3'b000, pat};
    exp_n++;
  endtask

  task automatic run(input logic [1:0] m, input int k, input logic [1:0] pat,
                     input logic [7:0] rev, input logic [7:0] rate,
                     input int fail_at, input bit disturb);
    bit saw_done, saw_err;
    int n;
    lane_mode = m; pattern_sel = pat; sink_rev = rev; rate_code = rate;
    set_levels(k);
    build_expected(m, pat, rev, rate);
    n = lanes_of(m);
    nwr = 0; err_at = fail_at;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    if (disturb) begin
      start = 1'b1; lane_mode = 2'd0; pattern_sel = ~pat;
      swing_lvl = ~swing_lvl; preemph_lvl = ~preemph_lvl; postcur_lvl = ~postcur_lvl;
      sink_rev = 8'h00;
      repeat (4) @(negedge clk);
      start = 1'b0;
    end
    saw_done = 0; saw_err = 0;
    for (int c = 0; c < 400 && !saw_done && !saw_err; c++) begin
      if (done) saw_done = 1;
      if (error) saw_err = 1;
      if (!saw_done && !saw_err) @(negedge clk);
    end
    if (fail_at != 0) begin
      check(saw_err && !saw_done, "R10 error pulse, no done", saw_done, 0);
      repeat (6) @(negedge clk);
      check(nwr == fail_at, "R10 no writes after failed ack", nwr, fail_at);
      check(busy == 1'b0, "R10 idle after abort", busy, 0);
      return;
    end
    check(saw_done && !saw_err, "R9 done without error", saw_err, 0);
    check(busy == 1'b0, "R9 busy low with done", busy, 0);
    check(nwr == exp_n, (rev >= 8'h12 && rate == 8'h14) ? "R5 write count" : "R3 write count",
          nwr, exp_n);
    for (int i = 0; i < exp_n && i < nwr; i++) begin
      string tag;
      tag = (i < n) ? "R1 drive byte" : (i == exp_n - 1) ? "R6 pattern byte" : "R4 post-cursor byte";
      check(got_addr[i] == exp_addr[i], {"R7 address order / ", tag}, got_addr[i], exp_addr[i]);
      check(got_data[i] == exp_data[i], tag, got_data[i], exp_data[i]);
    end
    check(got_addr[0] == 16'h0103, "R2 burst starts at lane 0", got_addr[0], 16'h0103);
    if (disturb) begin
      repeat (6) @(negedge clk);
      check(nwr == exp_n && busy == 1'b0, "R11 start while busy ignored", nwr, exp_n);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12
    check(!wr_valid && !busy && !done && !error, "R12 reset state",
          {wr_valid, busy, done, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr_valid && !busy, "R12 idle after reset", {wr_valid, busy}, 0);
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 4; p++)
        for (int r = 0; r < 2; r++)
          for (int q = 0; q < 2; q++)
            run(2'(m), m * 8 + p * 2 + r + q, 2'(p), r ? 8'h12 : 8'h11,
                q ? 8'h14 : 8'h0A, 0, 1'b0);
    run(2'd2, 5, 2'd2, 8'h14, 8'h14, 0, 1'b1);   // R11
    run(2'd2, 3, 2'd1, 8'h12, 8'h14, 2, 1'b0);   // R10
    run(2'd1, 7, 2'd3, 8'h13, 8'h14, 0, 1'b0);   // recovery after abort
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule